// File: doc/BRIEF.md
# Absolute to Physical Address Mapper

This block turns an absolute address into a physical address for accesses made while virtual translation is switched off. A 64-bit absolute address enters with two mode flags. One flag selects wide mode, in which the address is cut to the implementation's physical width and sign-extended. The other marks a legacy architecture, whose narrow-mode addresses are plain 32-bit values.

In narrow mode on the current architecture, the top nibbles of the low word sort the address into one of three regions: memory, I/O or firmware. Each region extends the 32-bit value in its own way. The firmware region is moved to the top of the physical space. The result is registered once and comes out with a valid strobe one cycle after the input strobe. It carries a region code and the access permission, which is always read, write and execute for an untranslated access.

Top module: `abs_phys_map`

## Requirements
- R1: With `wide_mode` = 1, `phys_addr` is the low PHYS_BITS bits of `abs_addr` (default 40), sign-extended to 64 bits. This holds whatever the value of `legacy_arch`, and `region` = 3.
- R2: With `wide_mode` = 0, `legacy_arch` = 0 and `abs_addr[31:28]` != 4'hF, the access is memory space: `phys_addr` = {32'h0, `abs_addr[31:0]`} and `region` = 0. Input bits 63:32 have no effect.
- R3: With `wide_mode` = 0, `legacy_arch` = 0, `abs_addr[31:28]` = 4'hF and `abs_addr[27:24]` != 0, the access is I/O space: `phys_addr` = `abs_addr[31:0]` sign-extended to 64 bits and `region` = 1.
- R4: With `wide_mode` = 0, `legacy_arch` = 0 and `abs_addr[31:24]` = 8'hF0, the access is firmware space: `phys_addr` = {32'h0, `abs_addr[31:0]`} with every bit from PHYS_BITS-4 through 63 set, and `region` = 2.
- R5: With `wide_mode` = 0 and `legacy_arch` = 1, `phys_addr` = {32'h0, `abs_addr[31:0]`} for every address, including 0xF0xxxxxx and 0xF1xxxxxx, and `region` = 0.
- R6: Whenever `out_vld` = 1, `perm` = 3'b111 (bit 0 read, bit 1 write, bit 2 execute).
- R7: `out_vld` is high exactly in the cycle after a cycle with `in_vld` high. While `in_vld` is low, `phys_addr`, `region` and `perm` are captured from nothing new, and `phys_addr` and `region` hold their last values.
- R8: In reset, `out_vld`, `phys_addr`, `region` and `perm` are all zero.
- R9: PHYS_BITS outside 36 to 54 is refused when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input address valid |
| abs_addr | input | 64 | Absolute address |
| wide_mode | input | 1 | 1 selects wide (truncate and sign-extend) mapping |
| legacy_arch | input | 1 | 1 selects flat 32-bit narrow mapping |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| phys_addr | output | 64 | Physical address |
| region | output | 2 | 0 memory, 1 I/O, 2 firmware, 3 wide |
| perm | output | 3 | Granted permission {execute, write, read} |

## Verification
The assertions check on every cycle the invariants a region code implies about the output's upper bits: zero above bit 31 for memory, ones above bit 31 for I/O, ones from PHYS_BITS-4 for firmware, and a uniform fill above PHYS_BITS-1 for wide. They also check the one-cycle strobe and full permission. Only the bench scenarios can show that the right region is chosen at the nibble boundaries (0xEFFFFFFF, 0xF0FFFFFF, 0xF1000000), that the low bits pass through unchanged, that the legacy flag overrides the region sort, and that ignored upper input bits leave the output alone.

// File: rtl/apm_pkg.sv
package apm_pkg;
   typedef enum logic [1:0] {
      RGN_MEM  = 2'd0,
      RGN_IO   = 2'd1,
      RGN_FW   = 2'd2,
      RGN_WIDE = 2'd3
   } rgn_e;

   localparam int unsigned ADDR_W   = 64;
   localparam int unsigned NARROW_W = 32;
   localparam logic [2:0]  PERM_ALL = 3'b111;
endpackage

// File: rtl/apm_region_decode.sv
module apm_region_decode
   import apm_pkg::*;
#(
   parameter int unsigned NIB_HI = 31
) (
   input  logic [NIB_HI:NIB_HI-7] top_byte,
   input  logic                   wide_mode,
   input  logic                   legacy_arch,
   output rgn_e                   region
);
   localparam int unsigned MID_LO = NIB_HI - 7;

   logic hi_all_ones;
   logic mid_zero;

   assign hi_all_ones = &top_byte[NIB_HI:NIB_HI-3];
   assign mid_zero    = ~|top_byte[NIB_HI-4:MID_LO];

   always_comb begin
      if (wide_mode)         region = RGN_WIDE;
      else if (legacy_arch)  region = RGN_MEM;
      else if (!hi_all_ones) region = RGN_MEM;
      else if (!mid_zero)    region = RGN_IO;
      else                   region = RGN_FW;
   end

   always_comb begin
      if (!wide_mode && legacy_arch)
         AST_LEGACY_FLAT: assert (region == RGN_MEM); // R5
   end
endmodule

// File: rtl/apm_extend.sv
module apm_extend
   import apm_pkg::*;
#(
   parameter int unsigned PHYS_BITS = 40
) (
   input  logic [ADDR_W-1:0] abs_addr,
   input  rgn_e              region,
   output logic [ADDR_W-1:0] phys_addr
);
   localparam int unsigned FILL_W  = ADDR_W - PHYS_BITS;
   localparam int unsigned FW_LSB  = PHYS_BITS - 4;
   localparam logic [ADDR_W-1:0] FW_MASK = {ADDR_W{1'b1}} << FW_LSB;

   logic [ADDR_W-1:0] wide_val;
   logic [ADDR_W-1:0] zext_val;
   logic [ADDR_W-1:0] sext_val;

   generate
      if (FILL_W > 0) begin : g_fill
         assign wide_val = {{FILL_W{abs_addr[PHYS_BITS-1]}}, abs_addr[PHYS_BITS-1:0]};
      end else begin : g_nofill
         assign wide_val = abs_addr;
      end
   endgenerate

   assign zext_val = {{(ADDR_W-NARROW_W){1'b0}}, abs_addr[NARROW_W-1:0]};
   assign sext_val = {{(ADDR_W-NARROW_W){abs_addr[NARROW_W-1]}}, abs_addr[NARROW_W-1:0]};

   always_comb begin
      unique case (region)
         RGN_WIDE: phys_addr = wide_val;
         RGN_IO:   phys_addr = sext_val;
         RGN_FW:   phys_addr = zext_val | FW_MASK;
         default:  phys_addr = zext_val;
      endcase
   end
endmodule

// File: rtl/abs_phys_map.sv
module abs_phys_map
   import apm_pkg::*;
#(
   parameter int unsigned PHYS_BITS = 40
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_vld,
   input  logic [63:0] abs_addr,
   input  logic        wide_mode,
   input  logic        legacy_arch,
   output logic        out_vld,
   output logic [63:0] phys_addr,
   output logic [1:0]  region,
   output logic [2:0]  perm
);
   localparam int unsigned FW_LSB   = PHYS_BITS - 4;
   localparam int unsigned SIGN_POS = PHYS_BITS - 1;

   generate
      if (PHYS_BITS > 54 || PHYS_BITS < 36) begin : g_bad_width
         $error("abs_phys_map: PHYS_BITS must lie in 36..54"); // R9
      end
   endgenerate

   rgn_e              rgn_c;
   logic [ADDR_W-1:0] phys_c;

   apm_region_decode #(.NIB_HI(NARROW_W-1)) i_decode (
      .top_byte    (abs_addr[NARROW_W-1:NARROW_W-8]),
      .wide_mode   (wide_mode),
      .legacy_arch (legacy_arch),
      .region      (rgn_c)
   );

   apm_extend #(.PHYS_BITS(PHYS_BITS)) i_extend (
      .abs_addr  (abs_addr),
      .region    (rgn_c),
      .phys_addr (phys_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld   <= 1'b0;
         phys_addr <= '0;
         region    <= RGN_MEM;
         perm      <= '0;
      end else begin
         out_vld <= in_vld;
         perm    <= in_vld ? PERM_ALL : 3'b000;
         if (in_vld) begin
            phys_addr <= phys_c;
            region    <= rgn_c;
         end
      end
   end

   AST_VLD_RISE:  assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld); // R7
   AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> !out_vld); // R7
   AST_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !in_vld |=> $stable(phys_addr)); // R7
   AST_PERM_ALL:  assert property (@(posedge clk) disable iff (!rst_n) out_vld |-> perm == PERM_ALL); // R6
   AST_MEM_ZEXT:  assert property (@(posedge clk) disable iff (!rst_n)
                     (out_vld && region == RGN_MEM) |-> phys_addr[63:32] == 32'h0); // R2
   AST_IO_SEXT:   assert property (@(posedge clk) disable iff (!rst_n)
                     (out_vld && region == RGN_IO) |-> (phys_addr[63:32] == 32'hFFFF_FFFF && phys_addr[31:28] == 4'hF)); // R3
   AST_FW_TOP:    assert property (@(posedge clk) disable iff (!rst_n)
                     (out_vld && region == RGN_FW) |-> &phys_addr[63:FW_LSB]); // R4
   AST_WIDE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
                     (out_vld && region == RGN_WIDE) |-> (&phys_addr[63:SIGN_POS] || ~|phys_addr[63:SIGN_POS])); // R1
endmodule

// File: tb/test_abs_phys_map.sv
module test_abs_phys_map;
   localparam int unsigned PB = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [63:0] abs_addr = '0;
   logic        wide_mode = 1'b0;
   logic        legacy_arch = 1'b0;
   logic        out_vld;
   logic [63:0] phys_addr;
   logic [1:0]  region;
   logic [2:0]  perm;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   abs_phys_map #(.PHYS_BITS(PB)) i_abs_phys_map (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .abs_addr(abs_addr),
      .wide_mode(wide_mode), .legacy_arch(legacy_arch), .out_vld(out_vld),
      .phys_addr(phys_addr), .region(region), .perm(perm)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected result from the requirement text
   function automatic logic [65:0] model(logic [63:0] a, logic w, logic lg);
      logic [63:0] p;
      logic [1:0]  r;
      if (w) begin
         p = a & ((64'd1 << PB) - 1);
         if (a[PB-1]) p = p | ~((64'd1 << PB) - 1);
         r = 2'd3;
      end else if (lg || a[31:28] != 4'hF) begin
         p = {32'h0, a[31:0]}; r = 2'd0;
      end else if (a[27:24] != 4'h0) begin
         p = {32'hFFFF_FFFF, a[31:0]}; r = 2'd1;
      end else begin
         p = {32'h0, a[31:0]} | (~64'd0 << (PB - 4)); r = 2'd2;
      end
      return {r, p};
   endfunction

   task automatic apply(string req, logic [63:0] a, logic w, logic lg);
      logic [65:0] e;
      e = model(a, w, lg);
      @(negedge clk);
      abs_addr = a; wide_mode = w; legacy_arch = lg; in_vld = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      check({req, " valid"}, {63'h0, out_vld}, 64'd1);
      check({req, " addr"}, phys_addr, e[63:0]);
      check({req, " region"}, {62'h0, region}, {62'h0, e[65:64]});
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R8 valid", {63'h0, out_vld}, 64'd0);
      check("R8 addr", phys_addr, 64'd0);
      check("R8 region", {62'h0, region}, 64'd0);
      check("R8 perm", {61'h0, perm}, 64'd0);
   endtask

   task automatic t_wide();
      apply("R1 positive", 64'h1234_5678_7ABC_DEF0, 1'b1, 1'b0);
      apply("R1 negative", 64'h0000_0080_0000_0001, 1'b1, 1'b0);
      apply("R1 legacy", 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 1'b1);
      check("R1 fixed", phys_addr, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic t_memory();
      apply("R2 low", 64'h0000_0000_0000_0000, 1'b0, 1'b0);
      apply("R2 edge", 64'hDEAD_BEEF_EFFF_FFFF, 1'b0, 1'b0);
      check("R2 fixed", phys_addr, 64'h0000_0000_EFFF_FFFF);
   endtask

   task automatic t_io();
      apply("R3 edge", 64'h0000_0000_F100_0000, 1'b0, 1'b0);
      check("R3 fixed", phys_addr, 64'hFFFF_FFFF_F100_0000);
      apply("R3 top", 64'h5555_0000_FFFF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_firmware();
      apply("R4 base", 64'h0000_0000_F000_0000, 1'b0, 1'b0);
      check("R4 fixed", phys_addr, 64'hFFFF_FFF0_F000_0000);
      apply("R4 edge", 64'hAAAA_AAAA_F0FF_FFFF, 1'b0, 1'b0);
   endtask

   task automatic t_legacy();
      apply("R5 fw", 64'h0000_0000_F000_1234, 1'b0, 1'b1);
      check("R5 fixed", phys_addr, 64'h0000_0000_F000_1234);
      apply("R5 io", 64'hFFFF_FFFF_F100_0000, 1'b0, 1'b1);
   endtask

   task automatic t_perm_hold();
      apply("R6 setup", 64'h0000_0000_1000_0000, 1'b0, 1'b0);
      check("R6 perm", {61'h0, perm}, 64'h7);
      @(negedge clk);
      abs_addr = 64'h0000_0000_F000_0000; wide_mode = 1'b1;
      @(negedge clk);
      check("R7 quiet valid", {63'h0, out_vld}, 64'd0);
      check("R7 hold addr", phys_addr, 64'h0000_0000_1000_0000);
      check("R7 hold region", {62'h0, region}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_wide();
      t_memory();
      t_io();
      t_firmware();
      t_legacy();
      t_perm_hold();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule